// File: doc/BRIEF.md
# SPI Channel Event Interrupt Collector

This block gathers the event pulses of a four-channel SPI controller into one pending-status register and drives a single level interrupt and a wake-up request from it. Every channel reports three events: transmit register empty, transmit underflow and receive register full. Channel 0 also reports a receive overflow, which only counts in slave mode. Two further sources apply to the whole module. One is an end-of-word-count pulse. The other is activity on the slave chip-select line chosen by a select input.

Software reads the pending bits and clears them by writing ones. It picks which pending bits may raise the interrupt through an enable register. A separate two-bit wake configuration decides whether a pending chip-select event may also drive the wake-up output. Two rules sit on top of the raw pulses. Turning a channel on marks its transmit register as empty at once. An underflow is held back until the channel's transmit register has been loaded at least once since the channel was turned on.

Top module: `spi_evt_irq`

## Requirements
- R1: After reset, the status, enable and wake configuration registers read as zero, and `irq` and `wake` are low.
- R2: A write to address 0 clears every status bit written as 1 and leaves every bit written as 0 unchanged. A status bit that reads 1 is pending. Status bit 4*i is tx-empty of channel i, bit 4*i+1 is tx-underflow, bit 4*i+2 is rx-full and bit 3 is the channel 0 rx-overflow. Bit 16 is end-of-word-count and bit 17 is the chip-select wake event.
- R3: When an event pulse and a clearing write reach the same status bit in the same cycle, the bit stays set.
- R4: A rising edge of `ch_en[i]` sets the tx-empty bit of channel i on the next clock edge. Per-channel event pulses have no effect while the channel is disabled.
- R5: A `tx_slot_miss[i]` pulse sets the underflow bit only if `tx_load[i]` has pulsed since channel i was last enabled. Disabling the channel re-arms this suppression.
- R6: Rx-overflow is recorded only for channel 0, with the channel enabled and `slave_mode` high. Bit 4*i+3 for i>0 and bits 31..18 always read zero in status and in enable, whatever is written.
- R7: `irq` equals the OR over all bits of (status AND enable), as registered on the clock edge after the status or enable change.
- R8: A `cs_act` pulse on the line selected by `cs_sel` sets bit 17, but only in slave mode. Pulses on other lines have no effect. `wake` goes high one cycle after bit 17 is pending, and only when wake configuration bit 0 (event wake enable) and bit 1 (global wake enable) are both 1.
- R9: Address 1 reads back the enable register and address 2 reads back the wake configuration in bits 1..0. Address 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_en | input | NCH | Channel enable levels |
| tx_load | input | NCH | Pulse: transmit register of channel loaded |
| tx_slot_miss | input | NCH | Pulse: transmit slot reached with empty register |
| tx_empty_ev | input | NCH | Pulse: transmit register empty |
| rx_full_ev | input | NCH | Pulse: receive register full |
| rx_ovf_ev | input | 1 | Pulse: channel 0 receive overflow |
| slave_mode | input | 1 | Module operates as SPI slave |
| eow_ev | input | 1 | Pulse: programmed word count reached |
| cs_act | input | NCS | Pulses: chip-select activity per line |
| cs_sel | input | CSW | Chip-select line watched for wake |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Read data for reg_addr (combinational) |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wake-up request |

## Verification
The bench looks for an underflow that slips through before the first load, or one that stays suppressed after a load. Either mistake shows up as a wrong bit 4*i+1. It also checks that a re-enable re-arms the suppression, which a design that forgets to drop its armed state on disable would get wrong. A clear that collides with a new event has to leave the bit set. A design that lets the clear win would lose the interrupt. The bench sweeps single-bit enables, every chip-select line against every selection, and all four wake configurations. These sweeps catch an interrupt or wake driven by the wrong bit, by the wrong line, or by only one of the two wake enables.

// File: rtl/spi_evt_irq.sv
module spi_evt_irq #(
  parameter int NCH = 4,
  parameter int NCS = 4,
  parameter int DW  = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NCH-1:0]         ch_en,
  input  logic [NCH-1:0]         tx_load,
  input  logic [NCH-1:0]         tx_slot_miss,
  input  logic [NCH-1:0]         tx_empty_ev,
  input  logic [NCH-1:0]         rx_full_ev,
  input  logic                   rx_ovf_ev,
  input  logic                   slave_mode,
  input  logic                   eow_ev,
  input  logic [NCS-1:0]         cs_act,
  input  logic [$clog2(NCS)-1:0] cs_sel,
  input  logic                   reg_wr,
  input  logic [1:0]             reg_addr,
  input  logic [DW-1:0]          reg_wdata,
  output logic [DW-1:0]          reg_rdata,
  output logic                   irq,
  output logic                   wake
);
  localparam int SW  = 4*NCH + 2;
  localparam int EOW = 4*NCH;
  localparam int WKB = 4*NCH + 1;

  logic [SW-1:0]  sts, ena, setv, vmask, clr;
  logic [1:0]     wcfg;
  logic [NCH-1:0] en_q, armed;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign setv[4*i]    = ch_en[i] & (~en_q[i] | tx_empty_ev[i]);
    assign setv[4*i+1]  = ch_en[i] & armed[i] & tx_slot_miss[i];
    assign setv[4*i+2]  = ch_en[i] & rx_full_ev[i];
    assign vmask[4*i+2 -: 3] = 3'b111;
    if (i == 0) begin : g_ovf
      assign setv[3]  = ch_en[0] & slave_mode & rx_ovf_ev;
      assign vmask[3] = 1'b1;
    end else begin : g_rsv
      assign setv[4*i+3]  = 1'b0;
      assign vmask[4*i+3] = 1'b0;
    end
  end

  assign setv[EOW]  = eow_ev;
  assign setv[WKB]  = slave_mode & cs_act[cs_sel];
  assign vmask[EOW] = 1'b1;
  assign vmask[WKB] = 1'b1;

  assign clr = (reg_wr && reg_addr == 2'd0) ? reg_wdata[SW-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts   <= '0;
      ena   <= '0;
      wcfg  <= '0;
      en_q  <= '0;
      armed <= '0;
      irq   <= 1'b0;
      wake  <= 1'b0;
    end else begin
      sts  <= ((sts & ~clr) | setv) & vmask;
      en_q <= ch_en;
      for (int i = 0; i < NCH; i++)
        armed[i] <= ch_en[i] & (armed[i] | tx_load[i]);
      if (reg_wr && reg_addr == 2'd1) ena  <= reg_wdata[SW-1:0] & vmask;
      if (reg_wr && reg_addr == 2'd2) wcfg <= reg_wdata[1:0];
      irq  <= |(sts & ena);
      wake <= sts[WKB] & (wcfg == 2'b11);
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      2'd0:    reg_rdata[SW-1:0] = sts;
      2'd1:    reg_rdata[SW-1:0] = ena;
      2'd2:    reg_rdata[1:0]    = wcfg;
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/spi_evt_irq_chk.sv
module spi_evt_irq_chk #(
  parameter int NCH = 4,
  parameter int DW  = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NCH-1:0]       ch_en,
  input logic [NCH-1:0]       tx_load,
  input logic [NCH-1:0]       tx_slot_miss,
  input logic                 eow_ev,
  input logic                 reg_wr,
  input logic [1:0]           reg_addr,
  input logic [DW-1:0]        reg_wdata,
  input logic [4*NCH+1:0]     sts,
  input logic [4*NCH+1:0]     ena,
  input logic [1:0]           wcfg,
  input logic                 irq,
  input logic                 wake
);
  localparam int EOW = 4*NCH;

  p_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0 && reg_wdata[EOW] && !eow_ev) |=> !sts[EOW]);

  p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0 && reg_wdata[EOW] && eow_ev) |=> sts[EOW]);

  for (genvar i = 0; i < NCH; i++) begin : g_c
    p_txe_on_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ch_en[i]) |=> sts[4*i]);
    p_no_early_ufl_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(ch_en[i]) && tx_slot_miss[i] && !sts[4*i+1]) |=> !sts[4*i+1]);
  end

  p_irq_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|(sts & ena)) |=> irq);
  p_irq_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(sts & ena)) |=> !irq);

  p_wake_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wcfg != 2'b11) |=> !wake);
endmodule

bind spi_evt_irq spi_evt_irq_chk #(.NCH(NCH), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .ch_en(ch_en), .tx_load(tx_load),
  .tx_slot_miss(tx_slot_miss), .eow_ev(eow_ev), .reg_wr(reg_wr),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .sts(sts), .ena(ena),
  .wcfg(wcfg), .irq(irq), .wake(wake)
);

// File: tb/spi_evt_irq_tb_top.sv
module spi_evt_irq_tb_top;
  localparam int NCH = 4, NCS = 4, DW = 32, SW = 4*NCH+2;

  logic clk = 0, rst_n = 0;
  logic [NCH-1:0] ch_en = 0, tx_load = 0, tx_slot_miss = 0, tx_empty_ev = 0, rx_full_ev = 0;
  logic rx_ovf_ev = 0, slave_mode = 0, eow_ev = 0, reg_wr = 0;
  logic [NCS-1:0] cs_act = 0;
  logic [1:0] cs_sel = 0, reg_addr = 0;
  logic [DW-1:0] reg_wdata = 0, reg_rdata;
  logic irq, wake;
  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] valid, exp_s;

  always #4 clk = ~clk;

  spi_evt_irq #(.NCH(NCH), .NCS(NCS), .DW(DW)) dut_i (.*);

  task automatic tick(); @(posedge clk); @(negedge clk); endtask

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", rq, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d; tick(); reg_wr = 0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic sts_is(string rq, logic [31:0] exp);
    logic [31:0] d; rd(0, d); chk(rq, d, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    valid = 0;
    for (int i = 0; i < NCH; i++) valid |= 32'h7 << (4*i);
    valid |= 32'h8 | (32'h3 << (4*NCH));
    @(negedge clk); tick(); tick(); rst_n = 1; tick();

    // R1 reset state, R9 address 3
    for (int a = 0; a < 4; a++) begin rd(a[1:0], d); chk("R1", d, 0); end
    chk("R1 irq", {31'b0, irq}, 0); chk("R1 wake", {31'b0, wake}, 0);

    // R6/R9 enable readback masked
    wr(1, 32'hFFFF_FFFF); rd(1, d); chk("R6 R9 enable mask", d, valid);
    wr(1, 0); wr(2, 32'hFFFF_FFFF); rd(2, d); chk("R9 cfg", d, 3);
    rd(3, d); chk("R9 addr3", d, 0); wr(2, 0);

    // R4 events ignored while disabled
    tx_empty_ev = '1; rx_full_ev = '1; tx_slot_miss = '1; tick();
    tx_empty_ev = 0; rx_full_ev = 0; tx_slot_miss = 0;
    sts_is("R4 disabled ignore", 0);

    // R4 enable raises tx-empty, per channel
    exp_s = 0;
    for (int i = 0; i < NCH; i++) begin
      ch_en[i] = 1; tick(); exp_s |= 32'h1 << (4*i);
      sts_is("R4 txe on enable", exp_s);
    end
    rx_full_ev = '1; eow_ev = 1; tick(); rx_full_ev = 0; eow_ev = 0;
    for (int i = 0; i < NCH; i++) exp_s |= 32'h4 << (4*i);
    exp_s |= 32'h1 << (4*NCH);
    sts_is("R2 pending", exp_s);

    // R7 single-bit enable sweep
    for (int b = 0; b < SW; b++) begin
      wr(1, 32'h1 << b); tick();
      chk("R7 irq", {31'b0, irq}, {31'b0, exp_s[b] & valid[b]});
    end
    wr(1, 0); tick(); chk("R7 irq off", {31'b0, irq}, 0);

    // R2 write-one-to-clear
    wr(0, 32'h0000_5555); exp_s &= ~32'h5555; sts_is("R2 clear", exp_s);
    wr(0, 0); sts_is("R2 zero write", exp_s);
    // R3 set wins
    reg_wr = 1; reg_addr = 0; reg_wdata = 32'h1 << (4*NCH); eow_ev = 1; tick();
    reg_wr = 0; eow_ev = 0; sts_is("R3 set wins", exp_s | (32'h1 << (4*NCH)));
    wr(0, 32'hFFFF_FFFF); sts_is("R2 all clear", 0);

    // R5 underflow suppression
    for (int i = 0; i < NCH; i++) begin
      ch_en[i] = 0; tick(); ch_en[i] = 1; tick(); wr(0, '1);
      tx_slot_miss[i] = 1; tick(); tx_slot_miss[i] = 0;
      sts_is("R5 no ufl before load", 0);
      tx_load[i] = 1; tick(); tx_load[i] = 0;
      tx_slot_miss[i] = 1; tick(); tx_slot_miss[i] = 0;
      sts_is("R5 ufl after load", 32'h2 << (4*i));
      ch_en[i] = 0; tick(); ch_en[i] = 1; tick(); wr(0, '1);
      tx_slot_miss[i] = 1; tick(); tx_slot_miss[i] = 0;
      sts_is("R5 rearmed", 0);
    end

    // R6 rx overflow
    rx_ovf_ev = 1; tick(); rx_ovf_ev = 0; sts_is("R6 ovf master", 0);
    slave_mode = 1; rx_ovf_ev = 1; tick(); rx_ovf_ev = 0;
    sts_is("R6 ovf slave", 32'h8); wr(0, '1);
    ch_en[0] = 0; rx_ovf_ev = 1; tick(); rx_ovf_ev = 0; ch_en[0] = 1; tick(); wr(0, '1);
    sts_is("R6 ovf disabled", 0);

    // R8 wake sweep
    for (int c = 0; c < 4; c++) begin
      wr(2, c);
      for (int s = 0; s < NCS; s++) begin
        for (int l = 0; l < NCS; l++) begin
          cs_sel = s[1:0]; cs_act = 1 << l; tick(); cs_act = 0;
          sts_is("R8 wake bit", (l == s) ? (32'h1 << (4*NCH+1)) : 0);
          tick();
          chk("R8 wake out", {31'b0, wake}, {31'b0, (l == s) && (c == 3)});
          wr(0, '1);
        end
      end
    end
    slave_mode = 0; cs_sel = 0; cs_act = 1; tick(); cs_act = 0;
    sts_is("R8 master no wake", 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule